// File: doc/BRIEF.md
# OTG Interrupt and Control Register Bank

This block is the software-visible register file of a dual-role USB controller. A simple synchronous bus (select, write strobe, address, write data, combinational read data) reaches five word registers: a control word, a PHY control word, an interrupt enable word, a sticky interrupt flag word cleared by writing ones, and a read-only word that mirrors the live session, ID, over-current and role inputs.

The dual-role state machine and the VBUS timers live elsewhere. They reach this bank as level inputs (session and role status) and one-cycle event pulses. The bank records either-edge changes of the session and ID levels, catches the role events, and latches the timer events into sticky flags. It drives one interrupt line from the enabled flags. It also clears the bus request bit and the role-swap enable bit in hardware when the state logic reports the transitions that end them.

Top module: `otg_irq_regbank`

## Requirements
- R1: After reset every register reads zero except the read-only status word, which shows the live inputs, and `irq` is low. A level that is already high while reset is held raises no change flag.
- R2: Writable bits are control {0,1,2,4,5}, PHY control {0,1,4,5} and interrupt enable {0..11,13}. Reserved bits read zero. Writes to the status word (0x10) are ignored, and unmapped addresses read zero. The byte offsets are 0x00 control, 0x04 PHY control, 0x08 enable, 0x0C flags, 0x10 status.
- R3: Status word bits: 0 over-current, 1 ID, 2 session end, 3 B-session valid, 4 A-session valid, 5 VBUS valid, 6 acting as peripheral, 7 acting as host.
- R4: A rising or a falling change sets a flag: ID sets bit 5, B-valid bit 8, A-valid bit 9, VBUS-valid bit 10 and session-end bit 11. The flag is visible one clock after the change is sampled.
- R5: The event pulses set flags: VBUS error sets bit 1, session-request fail bit 2, role-swap fail bit 3, go-idle bit 4 and session-request detected bit 13.
- R6: A rising acting-as-peripheral input sets bit 6 and a rising acting-as-host input sets bit 7. Bit 0 is set when the role moves directly between host and peripheral in a cycle where the ID level does not change.
- R7: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R8: If a hardware set and a write-1 clear reach the same flag in one cycle, the flag stays set.
- R9: `irq` is high exactly when some flag bit and its enable bit are both 1.
- R10: Control bit 1 (bus request) is cleared when control bit 0 (VBUS drop) is 1 after a write, when the ID level changes, or on the bus-request-drop pulse. The clear wins over a write of 1.
- R11: Control bit 2 (role-swap enable) is cleared by the swap-transition pulse or by the go-idle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busSel | input | 1 | Bus access select |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for the presented address |
| idPin | input | 1 | ID level (1 = B side) |
| sessEnd | input | 1 | Session-end level |
| bSessVld | input | 1 | B-session valid level |
| aSessVld | input | 1 | A-session valid level |
| vbusVld | input | 1 | VBUS valid level |
| overCur | input | 1 | Over-current level |
| actHost | input | 1 | Currently acting as host |
| actPeri | input | 1 | Currently acting as peripheral |
| evVbusErr | input | 1 | VBUS error pulse |
| evSrpFail | input | 1 | Session request fail pulse |
| evSwapFail | input | 1 | Role-swap fail pulse |
| evGoIdle | input | 1 | Return-to-idle pulse |
| evSrpSeen | input | 1 | Session request detected pulse |
| evSwapDone | input | 1 | Swap transition pulse, clears role-swap enable |
| evBusReqDrop | input | 1 | Pulse that clears bus request |
| irq | output | 1 | Interrupt request |
| ctlBits | output | 6 | Control register contents |
| phyBits | output | 6 | PHY control register contents |

## Verification
The bench builds the bank with ADDR_W = 6 and DATA_W = 32. The wider address lets it reach 0x14 and 0x20, which are outside the map, and confirm that they read zero and do not alias the five registers. The 32-bit data path lets all-ones writes show that every reserved bit above bit 13 reads zero.

// File: rtl/otg_regbank_pkg.sv
package otg_regbank_pkg;

  localparam int FLAG_W = 14;
  localparam int CTRL_W = 6;
  localparam int LVL_W  = 8;
  localparam int HIT_W  = 5;
  localparam int N_EDGE = 5;
  localparam int N_EVT  = 5;

  // flag positions (shared by enable word)
  localparam int F_ROLE    = 0;
  localparam int F_VBERR   = 1;
  localparam int F_SRPFAIL = 2;
  localparam int F_SWFAIL  = 3;
  localparam int F_IDLE    = 4;
  localparam int F_ID      = 5;
  localparam int F_PERI    = 6;
  localparam int F_HOST    = 7;
  localparam int F_BVLD    = 8;
  localparam int F_AVLD    = 9;
  localparam int F_VBVLD   = 10;
  localparam int F_SEND    = 11;
  localparam int F_SRPDET  = 13;
  localparam logic [FLAG_W-1:0] FLAG_MASK = 14'h2FFF;

  // level word positions
  localparam int L_OVC  = 0;
  localparam int L_ID   = 1;
  localparam int L_SEND = 2;
  localparam int L_BVLD = 3;
  localparam int L_AVLD = 4;
  localparam int L_VBV  = 5;
  localparam int L_PERI = 6;
  localparam int L_HOST = 7;

  // control word positions
  localparam int C_DROP   = 0;
  localparam int C_BUSREQ = 1;
  localparam int C_SWAP   = 2;
  localparam logic [CTRL_W-1:0] CTL_MASK = 6'h37;
  localparam logic [CTRL_W-1:0] PHY_MASK = 6'h33;

  // byte offsets
  localparam int OFF_CTL = 'h00;
  localparam int OFF_PHY = 'h04;
  localparam int OFF_IEN = 'h08;
  localparam int OFF_STS = 'h0C;
  localparam int OFF_LVL = 'h10;

  // register hit index
  localparam int H_CTL = 0;
  localparam int H_PHY = 1;
  localparam int H_IEN = 2;
  localparam int H_STS = 3;
  localparam int H_LVL = 4;

  typedef struct packed {
    logic [HIT_W-1:0]  hit;
    logic              wrCtl;
    logic              wrPhy;
    logic              wrIen;
    logic              clrSts;
    logic              busReqClr;
    logic              swapClr;
    logic [FLAG_W-1:0] flagSet;
  } strobe_t;

  function automatic int edgeSrc(int i);
    case (i)
      0: return L_ID;
      1: return L_BVLD;
      2: return L_AVLD;
      3: return L_VBV;
      default: return L_SEND;
    endcase
  endfunction

  function automatic int edgeDst(int i);
    case (i)
      0: return F_ID;
      1: return F_BVLD;
      2: return F_AVLD;
      3: return F_VBVLD;
      default: return F_SEND;
    endcase
  endfunction

  function automatic int evtDst(int i);
    return (i < 4) ? i + 1 : F_SRPDET;
  endfunction

endpackage

// File: rtl/otg_regbank_ctrl.sv
module otg_regbank_ctrl
  import otg_regbank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [LVL_W-1:0]  lvl,
  input  logic [N_EVT-1:0]  evtIn,
  input  logic              evSwapDone,
  input  logic              evBusReqDrop,
  output strobe_t           strb
);

  if (ADDR_W < 5) begin : gAddrChk
    $error("ADDR_W must cover offset 0x10");
  end

  logic [LVL_W-1:0]  lvlPrev;
  logic [FLAG_W-1:0] setVec;
  logic [N_EDGE-1:0] edgeHit;
  logic [HIT_W-1:0]  hitVec;
  logic              idMoved;
  logic              roleFlip;

  // previous levels load during reset so no false edge appears
  always_ff @(posedge clk) begin
    lvlPrev <= lvl;
  end

  for (genvar g = 0; g < N_EDGE; g++) begin : gEdge
    localparam int SRC = edgeSrc(g);
    assign edgeHit[g] = lvl[SRC] ^ lvlPrev[SRC];
  end

  assign idMoved  = edgeHit[0];
  assign roleFlip = ((lvlPrev[L_HOST] && lvl[L_PERI] && !lvl[L_HOST]) ||
                     (lvlPrev[L_PERI] && lvl[L_HOST] && !lvl[L_PERI])) && !idMoved;

  always_comb begin
    setVec = '0;
    for (int i = 0; i < N_EDGE; i++) begin
      if (edgeHit[i]) setVec[edgeDst(i)] = 1'b1;
    end
    for (int i = 0; i < N_EVT; i++) begin
      if (evtIn[i]) setVec[evtDst(i)] = 1'b1;
    end
    if (lvl[L_PERI] && !lvlPrev[L_PERI]) setVec[F_PERI] = 1'b1;
    if (lvl[L_HOST] && !lvlPrev[L_HOST]) setVec[F_HOST] = 1'b1;
    if (roleFlip) setVec[F_ROLE] = 1'b1;
  end

  assign hitVec[H_CTL] = busAddr == ADDR_W'(OFF_CTL);
  assign hitVec[H_PHY] = busAddr == ADDR_W'(OFF_PHY);
  assign hitVec[H_IEN] = busAddr == ADDR_W'(OFF_IEN);
  assign hitVec[H_STS] = busAddr == ADDR_W'(OFF_STS);
  assign hitVec[H_LVL] = busAddr == ADDR_W'(OFF_LVL);

  always_comb begin
    strb           = '0;
    strb.hit       = hitVec;
    strb.wrCtl     = busSel && busWr && hitVec[H_CTL];
    strb.wrPhy     = busSel && busWr && hitVec[H_PHY];
    strb.wrIen     = busSel && busWr && hitVec[H_IEN];
    strb.clrSts    = busSel && busWr && hitVec[H_STS];
    strb.busReqClr = evBusReqDrop || idMoved;
    strb.swapClr   = evSwapDone || evtIn[F_IDLE - 1];
    strb.flagSet   = setVec & FLAG_MASK;
  end

  // R2: address decode selects at most one register
  p_decode_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.hit));

  // R4: an ID level change always raises its flag request
  p_id_edge_r4: assert property (@(posedge clk) disable iff (!rstN)
    (lvl[L_ID] != $past(lvl[L_ID])) |-> strb.flagSet[F_ID]);

  // R6: role-change request never coincides with an ID change
  p_role_id_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lvl[L_ID] != $past(lvl[L_ID])) |-> !strb.flagSet[F_ROLE]);

endmodule

// File: rtl/otg_regbank_datapath.sv
module otg_regbank_datapath
  import otg_regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [LVL_W-1:0]  lvl,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq,
  output logic [CTRL_W-1:0] ctlQ,
  output logic [CTRL_W-1:0] phyQ
);

  logic [FLAG_W-1:0] ienQ;
  logic [FLAG_W-1:0] stsQ;
  logic [CTRL_W-1:0] ctlNext;
  logic [FLAG_W-1:0] stsNext;
  logic [FLAG_W-1:0] clrVec;

  always_comb begin
    ctlNext = strb.wrCtl ? (busWdata[CTRL_W-1:0] & CTL_MASK) : ctlQ;
    if (strb.busReqClr || ctlNext[C_DROP]) ctlNext[C_BUSREQ] = 1'b0;
    if (strb.swapClr) ctlNext[C_SWAP] = 1'b0;
  end

  assign clrVec  = strb.clrSts ? busWdata[FLAG_W-1:0] : '0;
  assign stsNext = ((stsQ & ~clrVec) | strb.flagSet) & FLAG_MASK;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ <= '0;
      phyQ <= '0;
      ienQ <= '0;
      stsQ <= '0;
    end else begin
      ctlQ <= ctlNext;
      stsQ <= stsNext;
      if (strb.wrPhy) phyQ <= busWdata[CTRL_W-1:0] & PHY_MASK;
      if (strb.wrIen) ienQ <= busWdata[FLAG_W-1:0] & FLAG_MASK;
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (1'b1)
      strb.hit[H_CTL]: busRdata[CTRL_W-1:0] = ctlQ;
      strb.hit[H_PHY]: busRdata[CTRL_W-1:0] = phyQ;
      strb.hit[H_IEN]: busRdata[FLAG_W-1:0] = ienQ;
      strb.hit[H_STS]: busRdata[FLAG_W-1:0] = stsQ;
      strb.hit[H_LVL]: busRdata[LVL_W-1:0]  = lvl;
      default:         busRdata = '0;
    endcase
  end

  assign irq = |(stsQ & ienQ);

  // R8: any requested flag is set on the next cycle, clear or not
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.flagSet != '0) |=> ((stsQ & $past(strb.flagSet)) == $past(strb.flagSet)));

  // R7: cleared bits without a concurrent set read back zero
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrSts |=> ((stsQ & $past(busWdata[FLAG_W-1:0]) & ~$past(strb.flagSet)) == '0));

  // R10: bus request falls after a hardware clear request
  p_busreq_clr_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.busReqClr |=> !ctlQ[C_BUSREQ]);

  // R11: swap enable falls after a swap-ending event
  p_swap_clr_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.swapClr |=> !ctlQ[C_SWAP]);

  // R9: with nothing enabled the line stays low
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ienQ == '0) |-> !irq);

endmodule

// File: rtl/otg_irq_regbank.sv
module otg_irq_regbank
  import otg_regbank_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              idPin,
  input  logic              sessEnd,
  input  logic              bSessVld,
  input  logic              aSessVld,
  input  logic              vbusVld,
  input  logic              overCur,
  input  logic              actHost,
  input  logic              actPeri,
  input  logic              evVbusErr,
  input  logic              evSrpFail,
  input  logic              evSwapFail,
  input  logic              evGoIdle,
  input  logic              evSrpSeen,
  input  logic              evSwapDone,
  input  logic              evBusReqDrop,
  output logic              irq,
  output logic [5:0]        ctlBits,
  output logic [5:0]        phyBits
);

  logic [LVL_W-1:0] lvl;
  logic [N_EVT-1:0] evtIn;
  strobe_t          strb;

  assign lvl   = {actHost, actPeri, vbusVld, aSessVld, bSessVld, sessEnd, idPin, overCur};
  assign evtIn = {evSrpSeen, evGoIdle, evSwapFail, evSrpFail, evVbusErr};

  otg_regbank_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .lvl(lvl), .evtIn(evtIn), .evSwapDone(evSwapDone),
    .evBusReqDrop(evBusReqDrop), .strb(strb)
  );

  otg_regbank_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata), .lvl(lvl),
    .busRdata(busRdata), .irq(irq), .ctlQ(ctlBits), .phyQ(phyBits)
  );

endmodule

// File: tb/sim_otg_irq_regbank.sv
module sim_otg_irq_regbank;
  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic [7:0] stv = 8'h02;
  logic [6:0] ev = '0;
  logic irq;
  logic [5:0] ctlBits, phyBits;

  int total = 0;
  int bad = 0;

  typedef struct { logic [DW-1:0] exp; string tag; } item_t;
  item_t expQ[$];

  always #10 clk = ~clk;

  otg_irq_regbank #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .idPin(stv[1]), .sessEnd(stv[2]), .bSessVld(stv[3]), .aSessVld(stv[4]),
    .vbusVld(stv[5]), .overCur(stv[0]), .actHost(stv[7]), .actPeri(stv[6]),
    .evVbusErr(ev[0]), .evSrpFail(ev[1]), .evSwapFail(ev[2]), .evGoIdle(ev[3]),
    .evSrpSeen(ev[4]), .evSwapDone(ev[5]), .evBusReqDrop(ev[6]),
    .irq(irq), .ctlBits(ctlBits), .phyBits(phyBits)
  );

  // monitor: compares read data against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (busSel && !busWr && expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        total++;
        if (busRdata !== it.exp) begin
          bad++;
          $display("FAIL %s: got %h want %h", it.tag, busRdata, it.exp);
        end
      end
    end
  end

  task automatic busWrite(input int addr, input logic [DW-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = AW'(addr); busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input int addr, input logic [DW-1:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    @(negedge clk);
    expQ.push_back(it);
    busSel = 1'b1; busWr = 1'b0; busAddr = AW'(addr);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic setLevels(input logic [7:0] v);
    @(negedge clk);
    stv = v;
  endtask

  task automatic pulse(input logic [6:0] m);
    @(negedge clk);
    ev = m;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic checkIrq(input logic e, input string tag);
    @(negedge clk);
    #5;
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s: irq got %b want %b", tag, irq, e);
    end
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog: got timeout want completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    busRead('h00, 0, "R1 ctl reset");
    busRead('h04, 0, "R1 phy reset");
    busRead('h08, 0, "R1 ien reset");
    busRead('h0C, 0, "R1 flags reset, no false edge");
    busRead('h10, 32'h02, "R3 status mirrors inputs");
    checkIrq(1'b0, "R1 irq reset");
    // R2 masks, read-only word, unmapped
    busWrite('h00, '1);
    busRead('h00, 32'h35, "R2/R10 ctl mask, drop clears busreq");
    busWrite('h04, '1);
    busRead('h04, 32'h33, "R2 phy mask");
    busWrite('h08, '1);
    busRead('h08, 32'h2FFF, "R2 ien mask");
    busWrite('h10, '1);
    busRead('h10, 32'h02, "R2 status write ignored");
    busRead('h14, 0, "R2 unmapped 0x14");
    busRead('h20, 0, "R2 unmapped 0x20");
    busWrite('h08, 0);
    busWrite('h00, 32'h16);
    busRead('h00, 32'h16, "R2 ctl write");
    // R4 either edge
    setLevels(8'h06);
    busRead('h0C, 32'h800, "R4 session end rise");
    busWrite('h0C, 32'h800);
    busRead('h0C, 0, "R7 w1c");
    setLevels(8'h02);
    busRead('h0C, 32'h800, "R4 session end fall");
    busWrite('h0C, 32'h800);
    setLevels(8'h3A);
    busRead('h0C, 32'h700, "R4 B/A/VBUS valid rise");
    busWrite('h0C, 0);
    busRead('h0C, 32'h700, "R7 write zero no effect");
    busWrite('h0C, 32'h700);
    setLevels(8'h38);
    busRead('h0C, 32'h20, "R4 ID fall");
    busRead('h00, 32'h14, "R10 ID change clears busreq");
    // R5 events
    pulse(7'h1F);
    busRead('h0C, 32'h203E, "R5 event flags");
    busRead('h00, 32'h10, "R11 go idle clears swap");
    busWrite('h0C, 32'hFFFF);
    busRead('h0C, 0, "R7 clear all");
    busWrite('h00, 32'h14);
    pulse(7'h20);
    busRead('h00, 32'h10, "R11 swap done clears swap");
    busWrite('h00, 32'h12);
    pulse(7'h40);
    busRead('h00, 32'h10, "R10 drop pulse clears busreq");
    // R6 roles
    setLevels(8'hB8);
    busRead('h0C, 32'h80, "R6 became host, no role flag");
    busWrite('h0C, 32'h80);
    setLevels(8'h78);
    busRead('h0C, 32'h41, "R6 host to peripheral");
    busRead('h10, 32'h78, "R3 status with role");
    busWrite('h0C, 32'h41);
    setLevels(8'hBA);
    busRead('h0C, 32'hA0, "R6 role flip with ID change");
    // R9 interrupt line
    checkIrq(1'b0, "R9 nothing enabled");
    busWrite('h08, 32'h20);
    checkIrq(1'b1, "R9 enabled flag");
    busWrite('h0C, 32'h20);
    checkIrq(1'b0, "R9 only unenabled flag left");
    // R8 set beats clear
    setLevels(8'hB2);
    busRead('h0C, 32'h180, "R4 B valid fall");
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = AW'('h0C); busWdata = 32'h100; stv = 8'hBA;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    busRead('h0C, 32'h180, "R8 set wins over clear");
    busWrite('h0C, 32'h180);
    busRead('h0C, 0, "R7 final clear");
    busRead('h10, 32'hBA, "R3 final status");
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule